// File: doc/BRIEF.md
# Soft-decision depuncturing front end

This block sits ahead of a Viterbi branch-metric stage. It takes a stream of 3-bit soft-decision channel symbols, one symbol per handshake beat. Each symbol is converted from either of two input codings into a signed confidence metric. Every two decoded-bit slots are assembled into one G1/G2 metric pair, and one pair is emitted per decoded bit. When descrambling is enabled, the G2 metric is inverted so that an encoder which flipped its G2 symbols is undone.

Punctured positions are restored as zero-weight erasures. In the internal modes a rate code picks one of three fixed puncture patterns. The block then inserts an erasure for every deleted slot and takes no input beat for that slot. A phase-offset input, meant for node-sync logic, rotates where the pattern starts. In the external mode every slot arrives as its own beat, and a per-beat puncture flag marks a slot whose value must be discarded.

Both streams use valid/ready handshakes. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. It is low while the current slot is a punctured one, and low while a finished pair waits on a stalled output. An output pair transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the pair stays on the port unchanged. The configuration inputs are plain levels and are expected to change only while the block is in reset.

Top module: `sd_depuncture_front`

## Requirements
- R1: With `fmt_offset`=1, codes 111,110,101,100 give metrics +4,+3,+2,+1 and codes 011,010,001,000 give -1,-2,-3,-4.
- R2: With `fmt_offset`=0, codes 111,110,101,100 give +4,+3,+2,+1 and codes 000,001,010,011 give -1,-2,-3,-4.
- R3: Hard-decision input with `fmt_offset`=0, the data bit on bit 2 and bits 1:0 tied high, gives +4 for code 111 and -4 for code 011.
- R4: With `descr_en`=1 the G2 metric of every pair is negated, the G1 metric is unchanged, and an erased G2 stays 0.
- R5: Rate code 001 selects the 2/3 pattern (G1 "10", G2 "11"), 100 selects 3/4 (G1 "101", G2 "110") and 010 selects 7/8 (G1 "1000101", G2 "1111010"). Pattern character i, counted from the left, applies to the i-th pair of a cycle, and 1 means the symbol was transmitted.
- R6: In an internal mode a punctured slot yields metric 0 with its erasure mark set and consumes no input beat; `in_ready` is low for that slot.
- R7: For rate code 000 and the unused codes 011, 101, 110 and 111, each pair takes two beats, G1 first and G2 second. A beat whose `in_pflag` is 1 yields metric 0 with its mark set, whatever its symbol value.
- R8: In the internal modes `in_pflag` has no effect.
- R9: The pattern position used for the k-th pair after reset (k from 0) is (k mod L + `phase_ofs`) mod L, where L is the pattern length: 2, 3 or 7.
- R10: While `out_valid`=1 and `out_ready`=0 the output pair is held stable; no pair is lost or repeated, and every beat with `in_valid`=1 and `in_ready`=1 is used exactly once.
- R11: After reset `out_valid` is 0, the pattern count is 0, the next slot is G1, and `in_ready` reflects whether that first slot is transmitted.
- R12: An output erasure mark is 1 exactly when its metric is 0; metrics of unerased symbols lie in ±1..±4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_offset | input | 1 | 1: offset binary input coding, 0: signed-magnitude style |
| descr_en | input | 1 | Negate G2 metrics (invert-G2 descramble) |
| rate_sel | input | 3 | Rate code selecting the puncture pattern or the external mode |
| phase_ofs | input | 3 | Rotation of the pattern start position |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle if valid |
| in_sym | input | 3 | Soft-decision symbol |
| in_pflag | input | 1 | External puncture flag for this beat |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_g1 | output | 4 | Signed G1 metric |
| out_g2 | output | 4 | Signed G2 metric |
| out_era1 | output | 1 | G1 erasure mark |
| out_era2 | output | 1 | G2 erasure mark |

## Verification
Walking through all eight codes in each coding separates the two conversion tables, and a hard-decision run shows that only the extremes appear. Each rate code is run from phase 0 and from non-zero offsets, with the offset up to 7 wrapping a length-2 pattern. These runs tell a misplaced pattern bit from a wrong pattern start or a wrong wrap point. The consumed-beat count shows whether a punctured slot wrongly took input. External-mode runs and internal-mode runs both use random flags, which shows the flag acts only where it should. Runs with sparse valid and ready interleave stalls with punctured slots to test the hold-stable rule.

// File: rtl/depunct_pkg.sv
package depunct_pkg;
  localparam int PAT_MAX   = 7;
  localparam int PAT_IDX_W = $clog2(PAT_MAX + 1);

  localparam logic [2:0] RC_HALF = 3'b000;
  localparam logic [2:0] RC_R23  = 3'b001;
  localparam logic [2:0] RC_R78  = 3'b010;
  localparam logic [2:0] RC_R34  = 3'b100;

  // Presence vectors, bit i = pair position i within the cycle.
  localparam logic [PAT_MAX-1:0] KEEP23_G1 = 7'b0000001;
  localparam logic [PAT_MAX-1:0] KEEP23_G2 = 7'b0000011;
  localparam logic [PAT_MAX-1:0] KEEP34_G1 = 7'b0000101;
  localparam logic [PAT_MAX-1:0] KEEP34_G2 = 7'b0000011;
  localparam logic [PAT_MAX-1:0] KEEP78_G1 = 7'b1010001;
  localparam logic [PAT_MAX-1:0] KEEP78_G2 = 7'b0101111;

  typedef struct packed {
    logic                 internal;
    logic [PAT_IDX_W-1:0] len;
    logic [PAT_MAX-1:0]   keep_g1;
    logic [PAT_MAX-1:0]   keep_g2;
  } pat_desc_t;

  function automatic pat_desc_t describe_rate(input logic [2:0] code);
    pat_desc_t d;
    d.internal = 1'b1;
    d.len      = PAT_IDX_W'(1);
    d.keep_g1  = '1;
    d.keep_g2  = '1;
    case (code)
      RC_R23: begin d.len = PAT_IDX_W'(2); d.keep_g1 = KEEP23_G1; d.keep_g2 = KEEP23_G2; end
      RC_R34: begin d.len = PAT_IDX_W'(3); d.keep_g1 = KEEP34_G1; d.keep_g2 = KEEP34_G2; end
      RC_R78: begin d.len = PAT_IDX_W'(7); d.keep_g1 = KEEP78_G1; d.keep_g2 = KEEP78_G2; end
      default: d.internal = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sd_metric_map.sv
module sd_metric_map #(
  parameter int SYM_W = 3,
  localparam int MET_W = SYM_W + 1
) (
  input  logic [SYM_W-1:0] sym,
  input  logic             fmt_offset,
  input  logic             negate,
  input  logic             erase,
  output logic [MET_W-1:0] metric,
  output logic             era
);
  localparam int HALF = 1 << (SYM_W - 1);
  localparam logic signed [MET_W-1:0] HALF_M = MET_W'(HALF);
  localparam logic signed [MET_W-1:0] ONE_M  = MET_W'(1);

  logic signed [MET_W-1:0] sv;
  logic signed [MET_W-1:0] base;

  always_comb begin
    sv = signed'({1'b0, sym});
    if (sym[SYM_W-1])   base = sv - HALF_M + ONE_M;  // upper half: +1..+HALF
    else if (fmt_offset) base = sv - HALF_M;          // offset binary lower half
    else                 base = -sv - ONE_M;          // magnitude grows away from zero
  end

  always_comb begin
    era = erase;
    if (erase)       metric = '0;
    else if (negate) metric = -base;
    else             metric = base;
  end
endmodule

// File: rtl/punct_pattern_sel.sv
module punct_pattern_sel
  import depunct_pkg::*;
(
  input  logic [2:0]           rate_sel,
  input  logic [PAT_IDX_W-1:0] phase_ofs,
  input  logic [PAT_IDX_W-1:0] pat_count,
  output logic                 internal_mode,
  output logic [PAT_IDX_W-1:0] pat_len,
  output logic                 keep_g1,
  output logic                 keep_g2
);
  pat_desc_t            desc;
  logic [PAT_IDX_W:0]   pos_sum;
  logic [PAT_IDX_W:0]   pos_wide;
  logic [PAT_IDX_W-1:0] pos;

  always_comb begin
    desc          = describe_rate(rate_sel);
    internal_mode = desc.internal;
    pat_len       = desc.len;
    pos_sum       = {1'b0, pat_count} + {1'b0, phase_ofs};
    pos_wide      = pos_sum % {1'b0, desc.len};
    pos           = pos_wide[PAT_IDX_W-1:0];
    keep_g1       = desc.keep_g1[pos];
    keep_g2       = desc.keep_g2[pos];
  end
endmodule

// File: rtl/pair_assembler.sv
module pair_assembler #(
  parameter int MET_W = 4,
  parameter int PC_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_present,
  input  logic [MET_W-1:0] slot_met,
  input  logic             slot_era,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  pat_len,
  output logic [PC_W-1:0]  pat_count,
  output logic             second_slot,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MET_W-1:0] out_g1,
  output logic [MET_W-1:0] out_g2,
  output logic             out_era1,
  output logic             out_era2
);
  logic             half_q;
  logic [PC_W-1:0]  cnt_q;
  logic [MET_W-1:0] hold_met_q;
  logic             hold_era_q;
  logic             can_go;
  logic             fill;
  logic [PC_W:0]    cnt_inc;
  logic             wrap;

  always_comb begin
    can_go   = !half_q || !out_valid || out_ready;
    in_ready = slot_present && can_go;
    fill     = can_go && (!slot_present || in_valid);
    cnt_inc  = {1'b0, cnt_q} + (PC_W+1)'(1);
    wrap     = cnt_inc >= {1'b0, pat_len};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      cnt_q      <= '0;
      hold_met_q <= '0;
      hold_era_q <= 1'b0;
      out_valid  <= 1'b0;
      out_g1     <= '0;
      out_g2     <= '0;
      out_era1   <= 1'b0;
      out_era2   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fill) begin
        if (!half_q) begin
          hold_met_q <= slot_met;
          hold_era_q <= slot_era;
          half_q     <= 1'b1;
        end else begin
          out_g1    <= hold_met_q;
          out_era1  <= hold_era_q;
          out_g2    <= slot_met;
          out_era2  <= slot_era;
          out_valid <= 1'b1;
          half_q    <= 1'b0;
          cnt_q     <= wrap ? '0 : cnt_inc[PC_W-1:0];
        end
      end
    end
  end

  assign pat_count   = cnt_q;
  assign second_slot = half_q;
endmodule

// File: rtl/sd_depuncture_front.sv
module sd_depuncture_front
  import depunct_pkg::*;
#(
  parameter int SYM_W = 3,
  localparam int MET_W = SYM_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fmt_offset,
  input  logic                 descr_en,
  input  logic [2:0]           rate_sel,
  input  logic [PAT_IDX_W-1:0] phase_ofs,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SYM_W-1:0]     in_sym,
  input  logic                 in_pflag,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [MET_W-1:0]     out_g1,
  output logic [MET_W-1:0]     out_g2,
  output logic                 out_era1,
  output logic                 out_era2
);
  logic                 internal_mode;
  logic [PAT_IDX_W-1:0] pat_len;
  logic [PAT_IDX_W-1:0] pat_count;
  logic                 keep_g1;
  logic                 keep_g2;
  logic                 second_slot;
  logic                 slot_present;
  logic                 slot_erase;
  logic [MET_W-1:0]     slot_met;
  logic                 slot_era;

  punct_pattern_sel u_pat (
    .rate_sel      (rate_sel),
    .phase_ofs     (phase_ofs),
    .pat_count     (pat_count),
    .internal_mode (internal_mode),
    .pat_len       (pat_len),
    .keep_g1       (keep_g1),
    .keep_g2       (keep_g2)
  );

  always_comb begin
    slot_present = second_slot ? keep_g2 : keep_g1;
    slot_erase   = !slot_present || (!internal_mode && in_pflag);
  end

  sd_metric_map #(.SYM_W(SYM_W)) u_map (
    .sym        (in_sym),
    .fmt_offset (fmt_offset),
    .negate     (descr_en && second_slot),
    .erase      (slot_erase),
    .metric     (slot_met),
    .era        (slot_era)
  );

  pair_assembler #(.MET_W(MET_W), .PC_W(PAT_IDX_W)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_present (slot_present),
    .slot_met     (slot_met),
    .slot_era     (slot_era),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .pat_len      (pat_len),
    .pat_count    (pat_count),
    .second_slot  (second_slot),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_g1       (out_g1),
    .out_g2       (out_g2),
    .out_era1     (out_era1),
    .out_era2     (out_era2)
  );
endmodule

// File: rtl/sd_depuncture_front_chk.sv
module sd_depuncture_front_chk #(
  parameter int MET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MET_W-1:0] out_g1,
  input logic [MET_W-1:0] out_g2,
  input logic             out_era1,
  input logic             out_era2
);
  localparam logic signed [MET_W-1:0] MAG_MAX = MET_W'(1 << (MET_W - 2));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_g1) && $stable(out_g2)
      && $stable(out_era1) && $stable(out_era2));

  // R12
  era_match_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_era1 == (out_g1 == '0)));

  // R12
  era_match_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_era2 == (out_g2 == '0)));

  // R1
  mag_range_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_g1) <= MAG_MAX) && ($signed(out_g1) >= -MAG_MAX));

  // R1
  mag_range_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_g2) <= MAG_MAX) && ($signed(out_g2) >= -MAG_MAX));
endmodule

bind sd_depuncture_front sd_depuncture_front_chk #(.MET_W(MET_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_g1    (out_g1),
  .out_g2    (out_g2),
  .out_era1  (out_era1),
  .out_era2  (out_era2)
);

// File: tb/sd_depuncture_front_bench.sv
module sd_depuncture_front_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_offset = 1'b0;
  logic       descr_en = 1'b0;
  logic [2:0] rate_sel = 3'b000;
  logic [2:0] phase_ofs = 3'b000;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_sym = 3'b000;
  logic       in_pflag = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [3:0] out_g1, out_g2;
  logic       out_era1, out_era2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [2:0] bsym [0:255];
  bit         bflg [0:255];
  logic [9:0] exp_pk [0:127];
  int         nb;
  bit         first_pres;

  always #2 clk = ~clk;

  sd_depuncture_front u_sd_depuncture_front (
    .clk(clk), .rst_n(rst_n), .fmt_offset(fmt_offset), .descr_en(descr_en),
    .rate_sel(rate_sel), .phase_ofs(phase_ofs), .in_valid(in_valid),
    .in_ready(in_ready), .in_sym(in_sym), .in_pflag(in_pflag),
    .out_valid(out_valid), .out_ready(out_ready), .out_g1(out_g1),
    .out_g2(out_g2), .out_era1(out_era1), .out_era2(out_era2));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic bit is_int(input logic [2:0] rc);
    return rc == 3'b001 || rc == 3'b100 || rc == 3'b010;
  endfunction

  function automatic int plen(input logic [2:0] rc);
    case (rc)
      3'b001: return 2;
      3'b100: return 3;
      3'b010: return 7;
      default: return 1;
    endcase
  endfunction

  // Pattern strings written left to right; character i applies to pair i.
  function automatic bit pat_bit(input logic [2:0] rc, input int idx, input int h);
    logic [6:0] a, b;
    int L;
    L = plen(rc);
    case (rc)
      3'b001: begin a = 7'b10;      b = 7'b11;      end
      3'b100: begin a = 7'b101;     b = 7'b110;     end
      3'b010: begin a = 7'b1000101; b = 7'b1111010; end
      default: begin a = 7'h7f;     b = 7'h7f;      end
    endcase
    return h != 0 ? b[L-1-idx] : a[L-1-idx];
  endfunction

  function automatic int map_sym(input int s, input bit fob);
    if (s >= 4) return s - 3;
    if (fob) return s - 4;
    return -s - 1;
  endfunction

  task automatic gen(input logic [2:0] rc, input logic [2:0] ofs, input bit fob,
                     input bit dsc, input int n, input int smode, input int fpct);
    int L;
    L = plen(rc);
    nb = 0;
    for (int p = 0; p < n; p++) begin
      int v[2];
      bit e[2];
      int eff;
      eff = ((p % L) + int'(ofs)) % L;
      for (int h = 0; h < 2; h++) begin
        bit pres;
        pres = is_int(rc) ? pat_bit(rc, eff, h) : 1'b1;
        if (p == 0 && h == 0) first_pres = pres;
        if (pres) begin
          logic [2:0] s;
          bit f;
          case (smode)
            1: s = 3'(nb);
            2: s = {1'($urandom), 2'b11};
            default: s = 3'($urandom);
          endcase
          f = ($urandom % 100) < fpct;
          bsym[nb] = s;
          bflg[nb] = f;
          nb++;
          if (!is_int(rc) && f) begin v[h] = 0; e[h] = 1'b1; end
          else begin v[h] = map_sym(int'(s), fob); e[h] = 1'b0; end
        end else begin
          v[h] = 0;
          e[h] = 1'b1;
        end
      end
      if (dsc) v[1] = -v[1];
      exp_pk[p] = {v[0][3:0], v[1][3:0], e[0], e[1]};
    end
  endtask

  task automatic run_seg(input string tag, input logic [2:0] rc, input logic [2:0] ofs,
                         input bit fob, input bit dsc, input int n, input int smode,
                         input int fpct, input int vpct, input int rpct);
    int bi, pk, cyc;
    bit hold_pend;
    logic [9:0] hold_val;
    gen(rc, ofs, fob, dsc, n, smode, fpct);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    rate_sel = rc; phase_ofs = ofs; fmt_offset = fob; descr_en = dsc;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state and first-slot readiness
    chk(!out_valid, "R11 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == first_pres, {tag, " R11 in_ready at first slot"}, int'(in_ready), int'(first_pres));
    bi = 0; pk = 0; cyc = 0; hold_pend = 0; hold_val = '0;
    while (pk < n && cyc < 4000) begin
      @(negedge clk);
      in_valid  = (bi < nb) && (($urandom % 100) < vpct);
      in_sym    = (bi < nb) ? bsym[bi] : 3'($urandom);
      in_pflag  = (bi < nb) ? bflg[bi] : 1'($urandom);
      out_ready = ($urandom % 100) < rpct;
      #1;
      if (hold_pend)
        chk(out_valid && {out_g1, out_g2, out_era1, out_era2} == hold_val, "R10 hold stable",
            int'({out_g1, out_g2, out_era1, out_era2}), int'(hold_val));
      hold_pend = out_valid && !out_ready;
      hold_val  = {out_g1, out_g2, out_era1, out_era2};
      if (out_valid && out_ready) begin
        chk({out_g1, out_g2, out_era1, out_era2} == exp_pk[pk], {tag, "/R12 pair"},
            int'({out_g1, out_g2, out_era1, out_era2}), int'(exp_pk[pk]));
        pk++;
      end
      if (in_valid && in_ready) bi++;
      cyc++;
    end
    chk(pk == n, {tag, " R10 pair count"}, pk, n);
    // R6: punctured slots must not consume beats
    chk(bi == nb, {tag, " R6 beats consumed"}, bi, nb);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    run_seg("R1", 3'b000, 3'd0, 1'b1, 1'b0, 16, 1, 0, 100, 100);
    run_seg("R2", 3'b000, 3'd0, 1'b0, 1'b0, 16, 1, 0, 100, 100);
    run_seg("R3", 3'b000, 3'd0, 1'b0, 1'b0, 24, 2, 0, 90, 90);
    run_seg("R4", 3'b000, 3'd0, 1'b1, 1'b1, 32, 1, 30, 90, 90);
    run_seg("R4", 3'b010, 3'd2, 1'b0, 1'b1, 28, 0, 0, 90, 90);
    run_seg("R5", 3'b001, 3'd0, 1'b1, 1'b0, 20, 0, 0, 100, 100);
    run_seg("R5", 3'b100, 3'd0, 1'b1, 1'b0, 21, 0, 0, 100, 100);
    run_seg("R5", 3'b010, 3'd0, 1'b0, 1'b0, 28, 0, 0, 100, 100);
    run_seg("R7", 3'b000, 3'd5, 1'b1, 1'b0, 40, 0, 50, 80, 80);
    run_seg("R7", 3'b111, 3'd0, 1'b0, 1'b0, 40, 0, 50, 80, 80);
    run_seg("R7", 3'b011, 3'd0, 1'b1, 1'b0, 20, 0, 50, 80, 80);
    run_seg("R8", 3'b010, 3'd0, 1'b1, 1'b0, 35, 0, 50, 80, 80);
    run_seg("R8", 3'b100, 3'd1, 1'b0, 1'b0, 30, 0, 50, 80, 80);
    run_seg("R9", 3'b010, 3'd3, 1'b1, 1'b0, 28, 0, 0, 90, 90);
    run_seg("R9", 3'b100, 3'd5, 1'b0, 1'b0, 24, 0, 0, 90, 90);
    run_seg("R9", 3'b001, 3'd7, 1'b1, 1'b0, 20, 0, 0, 90, 90);
    run_seg("R9", 3'b010, 3'd6, 1'b0, 1'b1, 21, 0, 0, 90, 90);
    run_seg("R10", 3'b100, 3'd2, 1'b1, 1'b0, 60, 0, 20, 40, 20);
    run_seg("R10", 3'b000, 3'd0, 1'b0, 1'b1, 60, 0, 20, 30, 25);
    for (int i = 0; i < 30; i++) begin
      logic [2:0] rc;
      rc = 3'($urandom);
      run_seg("R5", rc, 3'($urandom), 1'($urandom), 1'($urandom), 20 + int'($urandom % 60),
              0, int'($urandom % 60), 30 + int'($urandom % 71), 30 + int'($urandom % 71));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule